// File: doc/BRIEF.md
# Edge-kicked watchdog timer

This block watches a processor for signs of a stall. Software proves it is alive by changing the level of a single kick input. Any change counts, whether the input goes from low to high or from high to low. If no change arrives within a fixed number of clock cycles, the block raises an expiry output. That output is meant to feed the manual-reset path of a reset generator. The resulting system reset then clears the timer again.

The kick input is taken through a two-flop synchronizer. An edge is found by comparing the newest synchronized sample with the one held a cycle earlier, so a pulse that lasts only one cycle still gives two kicks. While the system reset input is high, the counter is held at zero. The counter also stays at zero while the enable input is low. Counting starts from zero on the first clock edge after both conditions clear. The timeout is a parameter given in clock cycles.

If the kick input never changes and the expiry output is looped back into reset, resets repeat. The period is the watchdog timeout plus the time for which the reset generator stretches its pulse.

Top module: `edge_kick_watchdog`

## Requirements
- R1: With enable high, reset low and no change on the kick input, the expiry output is low after release edges 1 to TIMEOUT_CYCLES-1 and high after edge TIMEOUT_CYCLES. Edges are counted from the first clock edge that samples reset low.
- R2: A low-to-high change on the kick input made between clock edges d and d+1 clears the timer at edge d+3. The expiry output is then high only after edge d+3+TIMEOUT_CYCLES, unless another change arrives first.
- R3: A high-to-low change on the kick input clears the timer in the same way as R2, with the same edge d+3 and the same expiry at d+3+TIMEOUT_CYCLES.
- R4: A pulse on the kick input that lasts exactly one clock cycle, starting between edges d and d+1, gives two kicks. The timer is cleared at edge d+3 and again at edge d+4, so the expiry output rises after edge d+4+TIMEOUT_CYCLES.
- R5: While system reset is high, the expiry output is low after every clock edge, and the count stays at zero. After reset is released, the timing of R1 applies again.
- R6: Once the expiry output is high, it stays high for as long as no kick is taken and reset stays low. A kick taken while it is high makes it low after that edge.
- R7: While enable is low, the expiry output is low after every edge, however long the kick input stays static. If enable is low at edge m and high from edge m+1 onward, expiry rises after edge m+TIMEOUT_CYCLES.
- R8: With the kick input static and the expiry output driving a reset held for S clock edges, expiry recurs every TIMEOUT_CYCLES+S edges. Each release is followed by exactly TIMEOUT_CYCLES edges before the next expiry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| sys_rst | input | 1 | Current system reset state, active high; holds the timer at zero |
| wdt_en | input | 1 | Watchdog enable, active high; when low the timer is held at zero |
| wdt_in | input | 1 | Kick input, asynchronous; either edge restarts the timer |
| wdt_expire | output | 1 | High when the timeout has elapsed without a kick |

## Verification
A level change on the kick input takes effect three clock edges later: two synchronizer edges, then one edge to clear the count. Expiry is therefore due TIMEOUT_CYCLES edges after that clearing edge, or TIMEOUT_CYCLES edges after the release of reset or enable. The bench places single changes and one-cycle pulses of both polarities at every offset, from early in the count to past expiry. It derives the expected level after each edge from the offset of the last kick and compares it on the falling clock edge after each rising edge. For the reset loop-back, the bench measures the number of edges from each release to expiry.

// File: rtl/edge_kick_watchdog.sv
module edge_kick_watchdog #(
  parameter int unsigned TIMEOUT_CYCLES = 1600000
) (
  input  logic clk,
  input  logic sys_rst,
  input  logic wdt_en,
  input  logic wdt_in,
  output logic wdt_expire
);

  localparam int CW = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYCLES);

  logic [2:0]    in_pipe;
  logic [CW-1:0] cnt;
  logic          kick;

  always_ff @(posedge clk)
    in_pipe <= {in_pipe[1:0], wdt_in};

  assign kick = in_pipe[2] ^ in_pipe[1];

  always_ff @(posedge clk) begin
    if (sys_rst || !wdt_en)
      cnt <= '0;
    else if (kick)
      cnt <= '0;
    else if (cnt != LIMIT)
      cnt <= cnt + 1'b1;
  end

  assign wdt_expire = (cnt == LIMIT);

  // R5
  rst_clear_chk: assert property (@(posedge clk) sys_rst |=> !wdt_expire);

  // R7
  en_off_chk: assert property (@(posedge clk) disable iff (sys_rst)
    !wdt_en |=> !wdt_expire);

  // R6
  expire_hold_chk: assert property (@(posedge clk) disable iff (sys_rst)
    wdt_expire && wdt_en && !kick |=> wdt_expire);

  // R2
  kick_drop_chk: assert property (@(posedge clk) disable iff (sys_rst)
    (in_pipe[1] != in_pipe[2]) |=> !wdt_expire);

  // R1
  rise_src_chk: assert property (@(posedge clk) disable iff (sys_rst)
    $rose(wdt_expire) |-> $past(wdt_en) && !$past(sys_rst));

endmodule

// File: tb/test_edge_kick_watchdog.sv
module test_edge_kick_watchdog;
  localparam int T = 20;
  localparam int S = 5;

  logic clk = 0;
  logic sys_rst = 1;
  logic wdt_en = 1;
  logic wdt_in = 0;
  logic wdt_expire;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  edge_kick_watchdog #(.TIMEOUT_CYCLES(T)) i_edge_kick_watchdog (
    .clk(clk), .sys_rst(sys_rst), .wdt_en(wdt_en),
    .wdt_in(wdt_in), .wdt_expire(wdt_expire));

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input logic got, input logic exp, input string req, input int n);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s edge %0d: expire=%0b expected %0b", req, n, got, exp);
    end
  endtask

  task automatic reset_seq(input logic v);
    sys_rst = 1; wdt_en = 1; wdt_in = v;
    for (int k = 1; k <= 4; k++) begin
      tick();
      check(wdt_expire, 1'b0, "R5 reset state", k);
    end
    sys_rst = 0;
  endtask

  task automatic single_edge(input logic v, input int d);
    int last;
    reset_seq(v);
    for (int n = 1; n <= d + T + 5; n++) begin
      tick();
      last = (n >= d + 3) ? d + 3 : 0;
      check(wdt_expire, (n - last) >= T, v ? "R3 falling kick / R6" : "R2 rising kick / R6", n);
      if (n == d) wdt_in = ~wdt_in;
    end
  endtask

  task automatic pulse(input logic v, input int d);
    int last;
    reset_seq(v);
    for (int n = 1; n <= d + T + 6; n++) begin
      tick();
      last = (n >= d + 4) ? d + 4 : ((n >= d + 3) ? d + 3 : 0);
      check(wdt_expire, (n - last) >= T, "R4 one-cycle pulse", n);
      if (n == d || n == d + 1) wdt_in = ~wdt_in;
    end
  endtask

  initial begin
    int n;
    // R1 and R6: static input, expiry at T, then held
    reset_seq(0);
    for (int k = 1; k <= 3 * T; k++) begin
      tick();
      check(wdt_expire, k >= T, "R1 timeout / R6 hold", k);
    end
    // R5: reset while expired, then timing restarts
    sys_rst = 1;
    for (int k = 1; k <= 3; k++) begin
      tick();
      check(wdt_expire, 1'b0, "R5 reset clears", k);
    end
    sys_rst = 0;
    for (int k = 1; k <= T + 2; k++) begin
      tick();
      check(wdt_expire, k >= T, "R5 restart after reset", k);
    end
    // R2, R3: single edges at every offset
    for (int d = 1; d <= T + 4; d++) begin
      single_edge(1'b0, d);
      single_edge(1'b1, d);
    end
    // R4: one-cycle pulses
    for (int d = 1; d <= T + 2; d++) begin
      pulse(1'b0, d);
      pulse(1'b1, d);
    end
    // R7: enable low
    reset_seq(0);
    wdt_en = 0;
    for (int k = 1; k <= 2 * T; k++) begin
      tick();
      check(wdt_expire, 1'b0, "R7 disabled", k);
      if (k == T) wdt_in = 1;
    end
    wdt_en = 1;
    for (int k = 1; k <= T + 2; k++) begin
      tick();
      check(wdt_expire, k >= T, "R7 enable restart", k);
    end
    // R8: expiry looped into a stretched reset
    reset_seq(0);
    for (int rep = 0; rep < 3; rep++) begin
      n = 0;
      do begin
        tick();
        n++;
      end while (!wdt_expire && n < 3 * T);
      checks++;
      if (n != T) begin
        fails++;
        $display("FAIL R8 loop period: %0d edges, expected %0d (period %0d)", n, T, T + S);
      end
      sys_rst = 1;
      for (int k = 1; k <= S; k++) begin
        tick();
        check(wdt_expire, 1'b0, "R8 stretched reset", k);
      end
      sys_rst = 0;
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run hung, 0 expected hangs");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule